// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block is a small, fully associative translation buffer that turns a virtual address into a physical address in one registered lookup cycle. Every entry is tagged with the process identifier that installed it. A lookup hits only when the entry is valid, its virtual page matches, and its tag identifier equals the contents of a writable current-process register. A context switch is therefore just a write to that register: entries that belong to other processes stay resident and lookups ignore them.

Each hit is checked against the entry's read, write and user-access permissions before any translation is given out. A permitted store marks the entry dirty, and the first time it does so the page identity is reported on a write-back port, so that the in-memory table entry can be updated. On a miss the block only raises a flag. An external agent walks the page table and installs the entry through a fill port. The fill port chooses a victim among the entries that are not the most recently used one. A fill whose table entry is not valid is refused and reported as a page fault. The lowest-numbered entries are kept for the operating system: only a fill marked supervisor may write them, and the invalidate-all command leaves them in place. A second command drops every entry that belongs to a given process.

Defaults: 16 entries, of which 2 are kept for the operating system; a 20-bit virtual page number; an 18-bit frame number; 8-bit process identifiers; 4 KB pages. The 12 offset bits pass through untranslated.

Top module: `ptlb_top`

## Requirements
- R1: After synchronous reset every entry is invalid, the current-process register and the most-recently-used index are 0, and every output is 0.
- R2: The result of a lookup appears in the cycle after `lk_req`. A permitted hit raises `lk_hit` with `lk_paddr` = {frame number, `lk_vaddr[11:0]`}. The virtual page is `lk_vaddr[31:12]`. When several entries match, the lowest index wins.
- R3: A lookup with no valid entry that matches both the page and the current process register raises `lk_miss`. Entries of other processes never hit.
- R4: A write through `pid_we` changes only the current-process register and invalidates nothing. Switching back to an earlier identifier hits that process's entries again.
- R5: A matching entry raises `lk_viol`, with no translation, when the access is in user mode (`lk_user`=1) and the entry's user bit is 0, or when it is a store and the write bit is 0, or when it is a load and the read bit is 0. `lk_paddr` is 0 whenever `lk_hit` is 0.
- R6: A permitted store sets the entry's dirty bit. Only on the store that changes that bit from 0 to 1, `wb_dirty` pulses together with the hit, carrying the entry's page in `wb_vpn` and its process identifier in `wb_pid`.
- R7: A fill with `fl_pte_vld`=0 installs nothing and raises `fl_fault` in the next cycle. `fl_fault` is never raised otherwise.
- R8: A fill picks its victim in this order. First, an entry of the target region that is valid with the same page and process identifier. Second, the lowest-index invalid entry of the region. Third, the lowest-index entry of the region that is not the most recently used one. A filled entry starts clean.
- R9: A permitted hit and every install both make that entry the most recently used one. A violation or a miss leaves the recency state unchanged.
- R10: Entries 0 to 1 are the reserved region. A fill with `fl_sup`=1 uses only that region, and a fill with `fl_sup`=0 uses only entries 2 to 15.
- R11: `inv_all` clears every entry except the reserved ones.
- R12: `inv_pid_en` clears every entry, reserved ones included, whose process identifier equals `inv_pid`, and no other entry.
- R13: Each lookup produces exactly one of hit, miss and violation. Without a lookup, none of them is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pid_we | input | 1 | Write the current-process register |
| pid_wdata | input | 8 | New process identifier |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user-mode access |
| fl_en | input | 1 | Fill request |
| fl_sup | input | 1 | Fill targets the reserved region |
| fl_vpn | input | 20 | Virtual page of the fill |
| fl_pid | input | 8 | Process identifier of the fill |
| fl_pfn | input | 18 | Frame number of the fill |
| fl_pte_vld | input | 1 | Valid bit of the supplied table entry |
| fl_perm_rd | input | 1 | Read permission |
| fl_perm_wr | input | 1 | Write permission |
| fl_perm_usr | input | 1 | User-mode access permitted |
| inv_all | input | 1 | Invalidate all non-reserved entries |
| inv_pid_en | input | 1 | Invalidate entries of one process |
| inv_pid | input | 8 | Process identifier to invalidate |
| lk_hit | output | 1 | Permitted hit |
| lk_miss | output | 1 | No matching entry |
| lk_viol | output | 1 | Access violation |
| lk_paddr | output | 30 | Translated physical address |
| wb_dirty | output | 1 | Dirty bit newly set on the reported page |
| wb_vpn | output | 20 | Page whose dirty bit was set |
| wb_pid | output | 8 | Process identifier of that page |
| fl_fault | output | 1 | Fill refused: page fault |

## Verification
The bound checker watches the lookup contract on every cycle. It checks that exactly one result follows each request and that nothing appears without one, that the offset passes through on a hit, and that the address is zero without a hit. It also checks that a dirty write-back only accompanies a store hit, that faults match invalid fills one to one, that invalidate-all spares the reserved entries, and that normal fills never bring a reserved entry to life. Only the bench's scenarios can show that a process switch leaves entries resident, which entry a full region evicts, that recency protects the last-used entry, and that each write-back is a first-time pulse. The bench shows these by comparing every lookup against a reference model, over directed sequences and a seeded random mix.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    localparam int TLB_N   = 16;
    localparam int TLB_RSV = 2;
    localparam int VPN_W   = 20;
    localparam int PFN_W   = 18;
    localparam int PID_W   = 8;
    localparam int OFS_W   = 12;
    localparam int IDX_W   = $clog2(TLB_N);
    localparam int VA_W    = VPN_W + OFS_W;
    localparam int PA_W    = PFN_W + OFS_W;

    typedef struct packed {
        logic rd;
        logic wr;
        logic usr;
    } perm_t;

    typedef struct packed {
        logic             vld;
        logic             dirty;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } ent_t;

    // Permission test for one access against one entry
    function automatic logic access_ok(perm_t p, logic is_store, logic user_mode);
        return (!user_mode || p.usr) && (is_store ? p.wr : p.rd);
    endfunction

    // Lowest set bit of an entry vector
    function automatic logic [IDX_W-1:0] lowest_set(logic [TLB_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = TLB_N - 1; i >= 0; i--)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam #(
    parameter int N  = 16,
    parameter int VW = 20,
    parameter int PW = 8
) (
    input  logic [N-1:0]  vld,
    input  logic [VW-1:0] tag_vpn [N],
    input  logic [PW-1:0] tag_pid [N],
    input  logic [VW-1:0] key_vpn,
    input  logic [PW-1:0] key_pid,
    output logic [N-1:0]  match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag_vpn[g] == key_vpn) && (tag_pid[g] == key_pid);
    end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
    parameter int N   = 16,
    parameter int RSV = 2,
    parameter int IW  = $clog2(N)
) (
    input  logic [N-1:0]  vld,
    input  logic [N-1:0]  same,
    input  logic [IW-1:0] mru,
    input  logic          sup,
    output logic [IW-1:0] vic
);
    logic [N-1:0] rmask, mru_oh, c_same, c_free, c_old;

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic IN_RSV = (g < RSV);
        assign rmask[g] = sup ? IN_RSV : !IN_RSV;
    end

    function automatic logic [IW-1:0] first(logic [N-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--)
            if (v[i]) r = IW'(i);
        return r;
    endfunction

    assign mru_oh = {{(N-1){1'b0}}, 1'b1} << mru;
    assign c_same = same & rmask;
    assign c_free = ~vld & rmask;
    assign c_old  = rmask & ~mru_oh;

    always_comb begin
        if (|c_same)      vic = first(c_same);
        else if (|c_free) vic = first(c_free);
        else if (|c_old)  vic = first(c_old);
        else              vic = first(rmask);
    end
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pid_we,
    input  logic [PID_W-1:0] pid_wdata,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_store,
    input  logic             lk_user,
    input  logic             fl_en,
    input  logic             fl_sup,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PID_W-1:0] fl_pid,
    input  logic [PFN_W-1:0] fl_pfn,
    input  logic             fl_pte_vld,
    input  logic             fl_perm_rd,
    input  logic             fl_perm_wr,
    input  logic             fl_perm_usr,
    input  logic             inv_all,
    input  logic             inv_pid_en,
    input  logic [PID_W-1:0] inv_pid,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_viol,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             wb_dirty,
    output logic [VPN_W-1:0] wb_vpn,
    output logic [PID_W-1:0] wb_pid,
    output logic             fl_fault
);
    ent_t             ents [TLB_N];
    logic [PID_W-1:0] pid_q;
    logic [IDX_W-1:0] mru_q;

    logic [TLB_N-1:0] ent_vld;
    logic [VPN_W-1:0] ent_vpn [TLB_N];
    logic [PID_W-1:0] ent_pid [TLB_N];

    for (genvar g = 0; g < TLB_N; g++) begin : g_flat
        assign ent_vld[g] = ents[g].vld;
        assign ent_vpn[g] = ents[g].vpn;
        assign ent_pid[g] = ents[g].pid;
    end

    // Lookup side
    logic [TLB_N-1:0] lk_match;
    logic [IDX_W-1:0] lk_idx;
    ent_t             lk_ent;
    logic             lk_any;

    ptlb_cam #(.N(TLB_N), .VW(VPN_W), .PW(PID_W)) u_lk_cam (
        .vld     (ent_vld),
        .tag_vpn (ent_vpn),
        .tag_pid (ent_pid),
        .key_vpn (lk_vaddr[VA_W-1:OFS_W]),
        .key_pid (pid_q),
        .match   (lk_match)
    );

    assign lk_any = |lk_match;
    assign lk_idx = lowest_set(lk_match);
    assign lk_ent = ents[lk_idx];

    // Fill side
    logic [TLB_N-1:0] fl_match;
    logic [IDX_W-1:0] fl_vic;
    ent_t             fl_ent;

    ptlb_cam #(.N(TLB_N), .VW(VPN_W), .PW(PID_W)) u_fl_cam (
        .vld     (ent_vld),
        .tag_vpn (ent_vpn),
        .tag_pid (ent_pid),
        .key_vpn (fl_vpn),
        .key_pid (fl_pid),
        .match   (fl_match)
    );

    ptlb_victim #(.N(TLB_N), .RSV(TLB_RSV), .IW(IDX_W)) u_victim (
        .vld  (ent_vld),
        .same (fl_match),
        .mru  (mru_q),
        .sup  (fl_sup),
        .vic  (fl_vic)
    );

    always_comb begin
        fl_ent          = '0;
        fl_ent.vld      = 1'b1;
        fl_ent.pid      = fl_pid;
        fl_ent.vpn      = fl_vpn;
        fl_ent.pfn      = fl_pfn;
        fl_ent.perm.rd  = fl_perm_rd;
        fl_ent.perm.wr  = fl_perm_wr;
        fl_ent.perm.usr = fl_perm_usr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TLB_N; i++) ents[i] <= '0;
            pid_q    <= '0;
            mru_q    <= '0;
            lk_hit   <= 1'b0;
            lk_miss  <= 1'b0;
            lk_viol  <= 1'b0;
            lk_paddr <= '0;
            wb_dirty <= 1'b0;
            wb_vpn   <= '0;
            wb_pid   <= '0;
            fl_fault <= 1'b0;
        end else begin
            lk_hit   <= 1'b0;
            lk_miss  <= 1'b0;
            lk_viol  <= 1'b0;
            lk_paddr <= '0;
            wb_dirty <= 1'b0;
            fl_fault <= 1'b0;

            if (pid_we) pid_q <= pid_wdata;

            if (lk_req) begin
                if (!lk_any) begin
                    lk_miss <= 1'b1;
                end else if (!access_ok(lk_ent.perm, lk_store, lk_user)) begin
                    lk_viol <= 1'b1;
                end else begin
                    lk_hit   <= 1'b1;
                    lk_paddr <= {lk_ent.pfn, lk_vaddr[OFS_W-1:0]};
                    mru_q    <= lk_idx;
                    if (lk_store) begin
                        ents[lk_idx].dirty <= 1'b1;
                        if (!lk_ent.dirty) begin
                            wb_dirty <= 1'b1;
                            wb_vpn   <= lk_ent.vpn;
                            wb_pid   <= lk_ent.pid;
                        end
                    end
                end
            end

            if (fl_en) begin
                if (!fl_pte_vld) begin
                    fl_fault <= 1'b1;
                end else begin
                    ents[fl_vic] <= fl_ent;
                    mru_q        <= fl_vic;
                end
            end

            if (inv_all)
                for (int i = TLB_RSV; i < TLB_N; i++) ents[i].vld <= 1'b0;

            if (inv_pid_en)
                for (int i = 0; i < TLB_N; i++)
                    if (ents[i].pid == inv_pid) ents[i].vld <= 1'b0;
        end
    end
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
    parameter int N     = 16,
    parameter int RSV   = 2,
    parameter int OFS_W = 12,
    parameter int VA_W  = 32,
    parameter int PA_W  = 30
) (
    input logic            clk,
    input logic            rst,
    input logic            lk_req,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_store,
    input logic            lk_hit,
    input logic            lk_miss,
    input logic            lk_viol,
    input logic [PA_W-1:0] lk_paddr,
    input logic            wb_dirty,
    input logic            fl_en,
    input logic            fl_sup,
    input logic            fl_pte_vld,
    input logic            fl_fault,
    input logic            inv_all,
    input logic            inv_pid_en,
    input logic [N-1:0]    ent_vld
);
    p_one_result_r13: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> ($countones({lk_hit, lk_miss, lk_viol}) == 1));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !(lk_hit || lk_miss || lk_viol));

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

    p_no_xlate_r5: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_paddr == '0));

    p_wb_on_store_r6: assert property (@(posedge clk) disable iff (rst)
        wb_dirty |-> (lk_hit && $past(lk_store)));

    p_bad_pte_r7: assert property (@(posedge clk) disable iff (rst)
        (fl_en && !fl_pte_vld) |=> fl_fault);

    p_fault_src_r7: assert property (@(posedge clk) disable iff (rst)
        fl_fault |-> $past(fl_en && !fl_pte_vld));

    p_keep_rsv_r11: assert property (@(posedge clk) disable iff (rst)
        (inv_all && !fl_en && !inv_pid_en) |=>
            (ent_vld[RSV-1:0] == $past(ent_vld[RSV-1:0])) && (ent_vld[N-1:RSV] == '0));

    p_rsv_guard_r10: assert property (@(posedge clk) disable iff (rst)
        (fl_en && !fl_sup) |=> ((ent_vld[RSV-1:0] & ~$past(ent_vld[RSV-1:0])) == '0));
endmodule

bind ptlb_top ptlb_chk #(
    .N     (ptlb_pkg::TLB_N),
    .RSV   (ptlb_pkg::TLB_RSV),
    .OFS_W (ptlb_pkg::OFS_W),
    .VA_W  (ptlb_pkg::VA_W),
    .PA_W  (ptlb_pkg::PA_W)
) u_chk (.*);

// File: tb/sim_ptlb_top.sv
`timescale 1ns/1ps
module sim_ptlb_top;
    import ptlb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             pid_we = 0;
    logic [PID_W-1:0] pid_wdata = '0;
    logic             lk_req = 0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic             lk_store = 0, lk_user = 0;
    logic             fl_en = 0, fl_sup = 0;
    logic [VPN_W-1:0] fl_vpn = '0;
    logic [PID_W-1:0] fl_pid = '0;
    logic [PFN_W-1:0] fl_pfn = '0;
    logic             fl_pte_vld = 0, fl_perm_rd = 0, fl_perm_wr = 0, fl_perm_usr = 0;
    logic             inv_all = 0, inv_pid_en = 0;
    logic [PID_W-1:0] inv_pid = '0;
    logic             lk_hit, lk_miss, lk_viol, wb_dirty, fl_fault;
    logic [PA_W-1:0]  lk_paddr;
    logic [VPN_W-1:0] wb_vpn;
    logic [PID_W-1:0] wb_pid;

    ptlb_top u0 (.*);

    int n_chk = 0, n_fail = 0;

    // Reference model
    logic             m_vld [TLB_N];
    logic             m_dty [TLB_N];
    logic [PID_W-1:0] m_pid [TLB_N];
    logic [VPN_W-1:0] m_vpn [TLB_N];
    logic [PFN_W-1:0] m_pfn [TLB_N];
    logic [2:0]       m_prm [TLB_N]; // {rd, wr, usr}
    int               m_mru;
    logic [PID_W-1:0] m_cur;

    function automatic void m_reset();
        for (int i = 0; i < TLB_N; i++) begin
            m_vld[i] = 0; m_dty[i] = 0; m_pid[i] = '0;
            m_vpn[i] = '0; m_pfn[i] = '0; m_prm[i] = '0;
        end
        m_mru = 0; m_cur = '0;
    endfunction

    function automatic int m_find(logic [VPN_W-1:0] vpn, logic [PID_W-1:0] pid, int lo, int hi);
        for (int i = lo; i < hi; i++)
            if (m_vld[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
        return -1;
    endfunction

    function automatic int m_victim(logic [VPN_W-1:0] vpn, logic [PID_W-1:0] pid, logic sup);
        int lo = sup ? 0 : TLB_RSV;
        int hi = sup ? TLB_RSV : TLB_N;
        int k = m_find(vpn, pid, lo, hi);
        if (k >= 0) return k;
        for (int i = lo; i < hi; i++) if (!m_vld[i]) return i;
        for (int i = lo; i < hi; i++) if (i != m_mru) return i;
        return lo;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        m_reset();
        n_chk++;
        if ({lk_hit, lk_miss, lk_viol, wb_dirty, fl_fault} !== 5'b0 || lk_paddr !== '0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %b/%h expected 00000/0",
                     {lk_hit, lk_miss, lk_viol, wb_dirty, fl_fault}, lk_paddr);
        end
    endtask

    task automatic do_lookup(input logic [VPN_W-1:0] vpn, input logic [OFS_W-1:0] ofs,
                             input logic st, input logic us, input string tag);
        int k;
        logic [2:0] e_res;  // {hit, miss, viol}
        logic [PA_W-1:0] e_pa;
        logic e_wb;
        logic [PID_W-1:0] e_wpid;
        k = m_find(vpn, m_cur, 0, TLB_N);
        e_pa = '0; e_wb = 0; e_wpid = m_cur;
        if (k < 0) e_res = 3'b010;
        else if ((us && !m_prm[k][0]) || (st ? !m_prm[k][1] : !m_prm[k][2])) e_res = 3'b001;
        else begin
            e_res = 3'b100;
            e_pa = {m_pfn[k], ofs};
            m_mru = k;
            if (st) begin
                e_wb = !m_dty[k];
                m_dty[k] = 1'b1;
            end
        end
        lk_req = 1; lk_vaddr = {vpn, ofs}; lk_store = st; lk_user = us;
        step();
        lk_req = 0;
        n_chk++;
        if ({lk_hit, lk_miss, lk_viol} !== e_res || lk_paddr !== e_pa || wb_dirty !== e_wb ||
            (e_wb && (wb_vpn !== vpn || wb_pid !== e_wpid))) begin
            n_fail++;
            $display("FAIL %s lookup vpn=%h: actual hmv=%b pa=%h wb=%b/%h/%h expected hmv=%b pa=%h wb=%b/%h/%h",
                     tag, vpn, {lk_hit, lk_miss, lk_viol}, lk_paddr, wb_dirty, wb_vpn, wb_pid,
                     e_res, e_pa, e_wb, vpn, e_wpid);
        end
    endtask

    task automatic do_fill(input logic sup, input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                           input logic [PFN_W-1:0] pfn, input logic pv, input logic [2:0] prm,
                           input string tag);
        int v;
        if (pv) begin
            v = m_victim(vpn, pid, sup);
            m_vld[v] = 1; m_dty[v] = 0; m_pid[v] = pid; m_vpn[v] = vpn;
            m_pfn[v] = pfn; m_prm[v] = prm; m_mru = v;
        end
        fl_en = 1; fl_sup = sup; fl_vpn = vpn; fl_pid = pid; fl_pfn = pfn; fl_pte_vld = pv;
        {fl_perm_rd, fl_perm_wr, fl_perm_usr} = prm;
        step();
        fl_en = 0;
        n_chk++;
        if (fl_fault !== !pv) begin
            n_fail++;
            $display("FAIL %s fill fault: actual %b expected %b", tag, fl_fault, !pv);
        end
    endtask

    task automatic do_pid(input logic [PID_W-1:0] p);
        m_cur = p;
        pid_we = 1; pid_wdata = p;
        step();
        pid_we = 0;
    endtask

    task automatic do_inv(input logic all, input logic [PID_W-1:0] p, input string tag);
        for (int i = 0; i < TLB_N; i++) begin
            if (all && i >= TLB_RSV) m_vld[i] = 0;
            if (!all && m_pid[i] == p) m_vld[i] = 0;
        end
        inv_all = all; inv_pid_en = !all; inv_pid = p;
        step();
        inv_all = 0; inv_pid_en = 0;
        n_chk++;
        if ({lk_hit, lk_miss, lk_viol} !== 3'b000) begin
            n_fail++;
            $display("FAIL %s idle outputs: actual %b expected 000", tag, {lk_hit, lk_miss, lk_viol});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual 200000 cycles expected completion earlier");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        m_reset();
        @(negedge clk);
        do_reset();                                              // R1
        do_lookup(20'h00010, 12'h123, 0, 0, "R1 empty");

        // R2 basic translation, R6 dirty write-back
        do_fill(0, 20'h00010, 8'd0, 18'h2abcd, 1, 3'b111, "R2");
        do_lookup(20'h00010, 12'h123, 0, 1, "R2 load");
        do_lookup(20'h00010, 12'hfff, 1, 0, "R6 first store");
        do_lookup(20'h00010, 12'h000, 1, 0, "R6 second store");

        // R3/R4 process switch
        do_pid(8'd5);
        do_lookup(20'h00010, 12'h010, 0, 0, "R3 other pid");
        do_fill(0, 20'h00010, 8'd5, 18'h00055, 1, 3'b111, "R4");
        do_lookup(20'h00010, 12'h010, 0, 0, "R4 pid5");
        do_pid(8'd0);
        do_lookup(20'h00010, 12'h020, 0, 0, "R4 back to pid0");

        // R5 protection
        do_fill(0, 20'h00020, 8'd0, 18'h00777, 1, 3'b100, "R5");
        do_lookup(20'h00020, 12'h004, 0, 1, "R5 user on sup page");
        do_lookup(20'h00020, 12'h004, 0, 0, "R5 sup load");
        do_lookup(20'h00020, 12'h004, 1, 0, "R5 store read-only");
        do_fill(0, 20'h00021, 8'd0, 18'h00778, 1, 3'b011, "R5");
        do_lookup(20'h00021, 12'h008, 0, 1, "R5 load not readable");

        // R7 invalid PTE
        do_fill(0, 20'h00030, 8'd0, 18'h00999, 0, 3'b111, "R7");
        do_lookup(20'h00030, 12'h000, 0, 0, "R7 not installed");

        // R8/R9/R10 replacement
        do_reset();
        do_fill(1, 20'h00300, 8'd0, 18'h03000, 1, 3'b110, "R10 sup");
        for (int i = 0; i < 14; i++)
            do_fill(0, 20'h00100 + i, 8'd0, 18'h01000 + i, 1, 3'b111, "R8 fill");
        do_lookup(20'h00100, 12'h000, 0, 0, "R9 make mru");
        do_fill(0, 20'h00200, 8'd0, 18'h02000, 1, 3'b111, "R8 evict");
        do_lookup(20'h00100, 12'h000, 0, 0, "R9 mru kept");
        do_lookup(20'h00101, 12'h000, 0, 0, "R8 victim gone");
        do_fill(0, 20'h00102, 8'd0, 18'h0abcd, 1, 3'b111, "R8 same page");
        do_lookup(20'h00102, 12'h044, 0, 0, "R8 refreshed");
        for (int i = 0; i < 20; i++)
            do_fill(0, 20'h00400 + i, 8'd0, 18'h04000 + i, 1, 3'b111, "R10 churn");
        do_lookup(20'h00300, 12'h0aa, 0, 0, "R10 reserved kept");

        // R11/R12 invalidation
        do_fill(0, 20'h00500, 8'd7, 18'h05000, 1, 3'b111, "R12");
        do_fill(1, 20'h00501, 8'd7, 18'h05001, 1, 3'b111, "R12");
        do_inv(0, 8'd7, "R12");
        do_pid(8'd7);
        do_lookup(20'h00500, 12'h000, 0, 0, "R12 normal cleared");
        do_lookup(20'h00501, 12'h000, 0, 0, "R12 reserved cleared");
        do_pid(8'd0);
        do_lookup(20'h00413, 12'h000, 0, 0, "R12 other pid kept");
        do_inv(1, 8'd0, "R11");
        do_lookup(20'h00413, 12'h000, 0, 0, "R11 normal cleared");
        do_lookup(20'h00300, 12'h000, 0, 0, "R11 reserved kept");

        // Random mix (R2..R13)
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(99);
            logic [VPN_W-1:0] v = VPN_W'($urandom_range(23));
            if (op < 50)
                do_lookup(v, OFS_W'($urandom), 1'($urandom), 1'($urandom), "R13 random");
            else if (op < 85)
                do_fill(1'($urandom_range(7) == 0), v, PID_W'($urandom_range(2)),
                        PFN_W'($urandom), $urandom_range(9) != 0, 3'($urandom), "R8 random");
            else if (op < 95)
                do_pid(PID_W'($urandom_range(2)));
            else if (op < 98)
                do_inv(0, PID_W'($urandom_range(2)), "R12 random");
            else
                do_inv(1, 8'd0, "R11 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule